// File: doc/BRIEF.md
# Multi-Channel LED Brightness and Group Dimming Engine

This block turns a bank of per-channel brightness settings into one registered "LED on" enable per channel. The enables stand in for the gates of open-drain current sinks. A free-running counter splits each 256-clock frame into phases. A channel is lit during the first N phases of every frame, where N is the channel's 8-bit brightness value. A slower group counter is shared by all channels and produces a second duty-cycle gate. Any channel can be combined with that gate, so a whole bank can fade or flash while each channel keeps its own level.

The group counter is driven by a two-state machine. In state GS_DIM the counter steps once every DIM_TICKS frames, which gives a slow dimming waveform of about 190 Hz. In state GS_BLINK it steps once every (freq+1)·BLINK_TICKS frames, which gives blink periods from about 1/24 s up to about 10.7 s. The machine follows a control bit. When it moves between states, either GS_DIM→GS_BLINK or GS_BLINK→GS_DIM, the group counter and its prescaler restart from zero. An active-low output enable overrides everything and turns all outputs off. All settings are loaded through a single-cycle parallel write port.

Top module: `led_pwm_engine`

## Requirements
- R1: Reset state. All outputs are low, every brightness is 0, every channel mode is 2, the group duty is 255, the control bit is 0 and the machine is in GS_DIM.
- R2: The frame counter runs 0..255, stepping once per clock. A channel in mode 2 with brightness N is on while the phase is below N: on for N of every 256 clocks, and never on when N=0.
- R3: Mode 0 keeps the output low. Mode 1 keeps it high while the output enable is active.
- R4: Mode 3 lights the channel only when the individual condition of R2 holds and the group condition (group counter below group duty) also holds.
- R5: In GS_DIM the group counter steps at the end of every DIM_TICKS-th frame and holds at all other times.
- R6: In GS_BLINK the group counter steps at the end of every ((freq+1)·BLINK_TICKS)-th frame.
- R7: A write of the control bit (bit 0 at address 2·NUM_CH+2; 1 selects GS_BLINK) changes state one clock later. That same clock clears the group counter and the prescaler.
- R8: While oe_n is high, every output goes low at the next clock edge, whatever the mode.
- R9: Write map: addresses 0..NUM_CH-1 hold brightness, NUM_CH..2·NUM_CH-1 hold the mode (data bits 1:0), 2·NUM_CH holds the group duty, 2·NUM_CH+1 holds the blink frequency, and 2·NUM_CH+2 holds the control bit. Writes to any other address change nothing.
- R10: Outputs are registered. A register written at one edge shows at the outputs after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 25 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable; high forces all outputs off |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| led_on | output | NUM_CH | Per-channel sink enable, high = LED lit |

## Verification
If the frame counter's phase is wrong, the on-time or the edges of a mode-2 channel move within one 256-clock frame. If the group counter or the state machine is wrong, mode-3 channels show gating against the wrong group count. That error can take one or more prescaled frames to appear, and it appears two clocks after a control-bit write for the reset of R7. A per-cycle reference model compares every output on every clock. Directed counts and single-cycle latency probes pin down zero brightness, ignored addresses and the output-enable override.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    // Per-channel output mode, encoded as written to the mode registers.
    typedef enum logic [1:0] {
        LM_OFF     = 2'd0,
        LM_ON      = 2'd1,
        LM_SOLO    = 2'd2,
        LM_GROUPED = 2'd3
    } led_mode_e;

    // Group counter pacing state.
    typedef enum logic {
        GS_DIM   = 1'b0,
        GS_BLINK = 1'b1
    } grp_state_e;

endpackage

// File: rtl/led_base_timer.sv
module led_base_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] phase,
    output logic             period_end
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign phase      = cnt_q;
    assign period_end = (cnt_q == '1);

endmodule

// File: rtl/led_group_pwm.sv
module led_group_pwm
    import led_pwm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIM_TICKS   = 2,
    parameter int BLINK_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic             blink_sel,
    input  logic [CNT_W-1:0] freq,
    input  logic [CNT_W-1:0] duty,
    output logic             grp_on
);

    localparam int PRE_W = CNT_W + $clog2(BLINK_TICKS + DIM_TICKS + 1) + 1;

    grp_state_e       state_q, state_d;
    logic [PRE_W-1:0] pre_q, lim;
    logic [CNT_W-1:0] gcnt_q;

    assign state_d = blink_sel ? GS_BLINK : GS_DIM;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_DIM;
        else        state_q <= state_d;
    end

    // Output / limit selection per state
    always_comb begin
        unique case (state_q)
            GS_DIM:   lim = PRE_W'(DIM_TICKS - 1);
            GS_BLINK: lim = (PRE_W'(freq) + PRE_W'(1)) * PRE_W'(BLINK_TICKS) - PRE_W'(1);
            default:  lim = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            gcnt_q <= '0;
        end else if (state_q != state_d) begin
            pre_q  <= '0;
            gcnt_q <= '0;
        end else if (period_end) begin
            if (pre_q >= lim) begin
                pre_q  <= '0;
                gcnt_q <= gcnt_q + 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
            end
        end
    end

    assign grp_on = (gcnt_q < duty);

    // R5: the group counter only moves at a frame end or on a state change
    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && state_q == state_d) |=> $stable(gcnt_q));

    // R7: a state change restarts the group counter
    assert_switch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != state_d) |=> (gcnt_q == '0));

endmodule

// File: rtl/led_channel.sv
module led_channel
    import led_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  led_mode_e        mode,
    input  logic [CNT_W-1:0] bright,
    input  logic [CNT_W-1:0] phase,
    input  logic             grp_on,
    input  logic             enable,
    output logic             led
);

    logic solo_on, next_on;

    assign solo_on = (phase < bright);

    always_comb begin
        unique case (mode)
            LM_OFF:     next_on = 1'b0;
            LM_ON:      next_on = 1'b1;
            LM_SOLO:    next_on = solo_on;
            LM_GROUPED: next_on = solo_on && grp_on;
            default:    next_on = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led <= 1'b0;
        else        led <= enable && next_on;
    end

    assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_OFF) |=> !led);

    assert_mode_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_ON && enable) |=> led);

    assert_zero_bright_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_SOLO && bright == '0) |=> !led);

    assert_group_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_GROUPED && !grp_on) |=> !led);

    assert_oe_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !led);

endmodule

// File: rtl/led_pwm_engine.sv
module led_pwm_engine
    import led_pwm_pkg::*;
#(
    parameter int NUM_CH      = 24,
    parameter int CNT_W       = 8,
    parameter int DIM_TICKS   = 2,
    parameter int BLINK_TICKS = 16,
    parameter int ADDR_W      = $clog2(2 * NUM_CH + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] led_on
);

    localparam logic [ADDR_W-1:0] A_GDUTY = ADDR_W'(2 * NUM_CH);
    localparam logic [ADDR_W-1:0] A_FREQ  = ADDR_W'(2 * NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(2 * NUM_CH + 2);

    logic [CNT_W-1:0] phase;
    logic             period_end;
    logic             grp_on;
    logic [CNT_W-1:0] gduty_q, freq_q;
    logic             blink_q;

    // Shared registers (R1 reset values, R9 addresses)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gduty_q <= '1;
            freq_q  <= '0;
            blink_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_GDUTY) gduty_q <= wr_data;
            if (wr_addr == A_FREQ)  freq_q  <= wr_data;
            if (wr_addr == A_CTRL)  blink_q <= wr_data[0];
        end
    end

    led_base_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .period_end (period_end)
    );

    led_group_pwm #(
        .CNT_W       (CNT_W),
        .DIM_TICKS   (DIM_TICKS),
        .BLINK_TICKS (BLINK_TICKS)
    ) u_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .blink_sel  (blink_q),
        .freq       (freq_q),
        .duty       (gduty_q),
        .grp_on     (grp_on)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_BR = ADDR_W'(i);
        localparam logic [ADDR_W-1:0] A_MD = ADDR_W'(NUM_CH + i);

        logic [CNT_W-1:0] br_q;
        led_mode_e        md_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                br_q <= '0;
                md_q <= LM_SOLO;
            end else if (wr_en) begin
                if (wr_addr == A_BR) br_q <= wr_data;
                if (wr_addr == A_MD) md_q <= led_mode_e'(wr_data[1:0]);
            end
        end

        led_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (md_q),
            .bright (br_q),
            .phase  (phase),
            .grp_on (grp_on),
            .enable (!oe_n),
            .led    (led_on[i])
        );
    end

endmodule

// File: tb/led_pwm_engine_tb.sv
`timescale 1ns/1ps
module led_pwm_engine_tb_top;

    localparam int NCH    = 24;
    localparam int AW     = 6;
    localparam int A_GD   = 2 * NCH;
    localparam int A_FR   = 2 * NCH + 1;
    localparam int A_CT   = 2 * NCH + 2;
    localparam int NSCEN  = 6;

    // Scenario vectors: group duty, freq, blink, mode seed, bright base, bright step, cycles
    localparam logic [7:0]  SC_GD   [NSCEN] = '{8'd255, 8'd128, 8'd0, 8'd5, 8'd2, 8'd200};
    localparam logic [7:0]  SC_FR   [NSCEN] = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0};
    localparam logic        SC_BL   [NSCEN] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          SC_SEED [NSCEN] = '{0, 1, 2, 3, 0, 1};
    localparam int          SC_BASE [NSCEN] = '{0, 255, 40, 128, 200, 1};
    localparam int          SC_STEP [NSCEN] = '{11, 7, 9, 3, 13, 1};
    localparam int          SC_CYC  [NSCEN] = '{2000, 3000, 1500, 8000, 3000, 66000};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            oe_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [NCH-1:0]  led_on;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    led_pwm_engine #(
        .NUM_CH(NCH), .CNT_W(8), .DIM_TICKS(1), .BLINK_TICKS(1), .ADDR_W(AW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .led_on(led_on)
    );

    // Reference model built from the requirements (DIM_TICKS=1, BLINK_TICKS=1)
    logic [7:0]     m_b, m_g, m_gd, m_fr;
    int unsigned    m_pre;
    logic           m_ctrl, m_state, m_oe_q;
    logic [7:0]     m_br [NCH];
    logic [1:0]     m_md [NCH];
    logic [NCH-1:0] m_exp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_b <= 0; m_g <= 0; m_pre <= 0; m_gd <= 8'd255; m_fr <= 0;
            m_ctrl <= 0; m_state <= 0; m_exp <= '0; m_oe_q <= 0;
            for (int i = 0; i < NCH; i++) begin m_br[i] <= 0; m_md[i] <= 2'd2; end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                logic solo;
                logic v;
                solo = m_b < m_br[i];
                case (m_md[i])
                    2'd0: v = 0;
                    2'd1: v = 1;
                    2'd2: v = solo;
                    default: v = solo && (m_g < m_gd);
                endcase
                m_exp[i] <= v && !oe_n;
            end
            m_oe_q <= oe_n;
            m_b <= m_b + 1;
            m_state <= m_ctrl;
            if (m_state != m_ctrl) begin
                m_pre <= 0; m_g <= 0;
            end else if (m_b == 8'hFF) begin
                int unsigned len;
                len = m_state ? (int'(m_fr) + 1) : 1;
                if (m_pre + 1 >= len) begin m_pre <= 0; m_g <= m_g + 1; end
                else m_pre <= m_pre + 1;
            end
            if (wr_en) begin
                for (int i = 0; i < NCH; i++) begin
                    if (int'(wr_addr) == i) m_br[i] <= wr_data;
                    if (int'(wr_addr) == NCH + i) m_md[i] <= wr_data[1:0];
                end
                if (int'(wr_addr) == A_GD) m_gd <= wr_data;
                if (int'(wr_addr) == A_FR) m_fr <= wr_data;
                if (int'(wr_addr) == A_CT) m_ctrl <= wr_data[0];
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (led_on !== m_exp) begin
                string tag;
                int k;
                k = 0;
                for (int i = NCH - 1; i >= 0; i--) if (led_on[i] !== m_exp[i]) k = i;
                if (m_oe_q) tag = "R8";
                else if (m_md[k] == 2'd3) tag = m_state ? "R4 R6 R7" : "R4 R5 R7";
                else if (m_md[k] == 2'd2) tag = "R2";
                else tag = "R3";
                n_bad++;
                $display("FAIL %s: ch%0d led_on act=%h exp=%h at %0t", tag, k, led_on, m_exp, $time);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_on(input int ch, output int cnt);
        cnt = 0;
        repeat (256) begin
            @(negedge clk);
            if (led_on[ch]) cnt++;
        end
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(led_on == '0, "R1 outputs after reset", int'(led_on), 0);
        idle(300);
        // R1: group duty default 255 lets a grouped full-bright channel light
        wr(NCH + 0, 3);
        wr(0, 255);
        idle(300);

        // Vector table walk
        for (int s = 0; s < NSCEN; s++) begin
            wr(A_GD, SC_GD[s]);
            wr(A_FR, SC_FR[s]);
            wr(A_CT, SC_BL[s]);
            for (int i = 0; i < NCH; i++) begin
                wr(i, 8'(SC_BASE[s] + i * SC_STEP[s]));
                wr(NCH + i, (i + SC_SEED[s]) % 4);
            end
            idle(SC_CYC[s]);
        end

        // R2: on-time equals brightness
        wr(A_CT, 0);
        wr(NCH + 0, 2);
        wr(0, 3);
        idle(2);
        count_on(0, c);
        check(c == 3, "R2 on-count for brightness 3", c, 3);
        // R9: unmapped address leaves settings untouched
        wr(60, 255);
        wr(51, 0);
        idle(2);
        count_on(0, c);
        check(c == 3, "R9 unmapped write ignored", c, 3);
        wr(0, 0);
        idle(2);
        count_on(0, c);
        check(c == 0, "R2 brightness 0 never on", c, 0);

        // R10: one edge from register update to output
        wr(NCH + 1, 0);
        idle(2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(NCH + 1); wr_data = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        check(led_on[1] == 1'b0, "R10 output not yet updated", int'(led_on[1]), 0);
        @(negedge clk);
        check(led_on[1] == 1'b1, "R10 output updated after one edge", int'(led_on[1]), 1);

        // R8: output enable overrides mode ON
        for (int i = 0; i < NCH; i++) wr(NCH + i, 1);
        idle(2);
        check(led_on == '1, "R3 all channels forced on", int'(led_on), 'hFFFFFF);
        @(negedge clk) oe_n = 1'b1;
        @(negedge clk);
        check(led_on == '0, "R8 oe_n high forces off", int'(led_on), 0);
        idle(300);
        @(negedge clk) oe_n = 1'b0;
        idle(2);

        // R7: switching to blink restarts the group counter
        wr(A_GD, 1);
        wr(A_FR, 0);
        wr(NCH + 0, 3);
        wr(0, 255);
        idle(600);
        wr(A_CT, 1);
        idle(2);
        check(led_on[0] == ((m_b - 8'd1) != 8'hFF), "R7 group count cleared on switch",
              int'(led_on[0]), int'((m_b - 8'd1) != 8'hFF));
        idle(600);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule